// File: doc/BRIEF.md
# Physical-Order March Address Generator

This block produces the address stream for a single March element inside a memory self-test engine. It does not count through the logical address bus value directly. It keeps a row counter and a column counter and turns each one into its logical address field through a dedicated bijective scramble. The row field and the column field are then joined to form the memory address. The test controller can therefore walk the cell array in true physical order, in logical order, or in a mixed order, chosen separately for rows and for columns.

A one-cycle start pulse latches the walk configuration: direction, column step of one or two cells, order per dimension, and an optional neighbourhood window around a victim cell. The walk then advances by one address for every clock cycle in which enable is high. The current physical row and column are reported next to the address, so that fault logging and repair analysis can work on array coordinates. In neighbourhood mode only the cells that touch the victim cell are visited. This supports aggressor search during diagnosis and avoids a pass over the whole array.

Top module: `phys_march_agen`

## Requirements
- R1: After reset, `busy_o` and `done_o` are both low.
- R2: The address is `{row_field, col_field}`, with the row field in the upper ROW_BITS bits. In physical order, row_field = rotate-left(physical row, ROW_ROT) XOR ROW_MASK, and col_field = rotate-left(physical column, COL_ROT) XOR COL_MASK. The defaults are ROT 1, mask 5 for rows and ROT 2, mask 3 for columns.
- R3: When a dimension is set to logical order (`row_phys`/`col_phys` = 0), its counter steps the logical field directly, and the reported physical index is the inverse scramble of that field. Rows and columns select their order independently, which includes the mixed mode of physical rows with logical columns.
- R4: The column is the inner loop and the row is the outer loop. With `dir_down` = 0 the walk starts at index 0 and counts up. With `dir_down` = 1 both counters start at the highest index and count down.
- R5: With `step_two` = 1 the column counter moves by 2 and rows still move by 1. Counting up therefore visits columns 0,2,4,…; counting down visits columns max, max-2, … (the odd columns).
- R6: While `enable` is low, the address and the physical row and column hold their values.
- R7: `done_o` rises, and `busy_o` falls, one cycle after the cycle in which the last address was issued with enable high. `done_o` stays high until the next start pulse, which clears it.
- R8: With `nbr_mode` = 1 the walk covers physical rows victim_row-1..victim_row+1 and columns victim_col-1..victim_col+1, clipped at the array edges. It uses physical order in both dimensions and a step of 1, follows `dir_down`, and never issues the victim cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: latch configuration and begin the walk |
| enable | input | 1 | Advance one address per cycle while high |
| dir_down | input | 1 | 0 count up, 1 count down |
| step_two | input | 1 | Column step of 2 instead of 1 |
| row_phys | input | 1 | Rows in physical (1) or logical (0) order |
| col_phys | input | 1 | Columns in physical (1) or logical (0) order |
| nbr_mode | input | 1 | Walk only the victim's neighbourhood |
| victim_row | input | ROW_BITS | Physical row of victim cell |
| victim_col | input | COL_BITS | Physical column of victim cell |
| addr_o | output | ROW_BITS+COL_BITS | Memory address {row field, column field} |
| phys_row_o | output | ROW_BITS | Physical row of current cell |
| phys_col_o | output | COL_BITS | Physical column of current cell |
| busy_o | output | 1 | Walk in progress; address valid |
| done_o | output | 1 | Walk complete |

## Verification
Full walks in physical order, counting up and counting down, separate a correct scramble and loop nesting from swapped fields or swapped loops. All-logical and mixed-order walks show whether each dimension's order is chosen independently, and whether the inverse mapping appears on the physical outputs. Step-two walks in both directions separate the even-column sequence from the odd-column sequence. Neighbourhood walks at a corner, at an edge and in the interior check the clipping and the skip of the victim cell, including the case where the victim cell would otherwise be the first address. A pause in enable in the middle of a walk and the persistence of done check the hold behaviour.

// File: rtl/phys_march_pkg.sv
package phys_march_pkg;
  typedef struct packed {
    logic down;
    logic step2;
    logic row_phys;
    logic col_phys;
    logic nbr;
  } walk_cfg_t;
endpackage

// File: rtl/fld_scramble.sv
module fld_scramble #(
  parameter int W    = 3,
  parameter int ROT  = 1,
  parameter int MASK = 5
) (
  input  logic [W-1:0] walk_val,
  input  logic         phys_mode,
  output logic [W-1:0] phys_idx,
  output logic [W-1:0] log_idx
);
  localparam int K = ROT % W;
  localparam logic [W-1:0] M = W'(MASK);

  function automatic logic [W-1:0] fwd(input logic [W-1:0] x);
    fwd = ((x << K) | (x >> (W - K))) ^ M;
  endfunction

  function automatic logic [W-1:0] inv(input logic [W-1:0] y);
    logic [W-1:0] t;
    t   = y ^ M;
    inv = (t >> K) | (t << (W - K));
  endfunction

  always_comb begin
    if (phys_mode) begin
      phys_idx = walk_val;
      log_idx  = fwd(walk_val);
    end else begin
      phys_idx = inv(walk_val);
      log_idx  = walk_val;
    end
  end
endmodule

// File: rtl/march_walk.sv
module march_walk
  import phys_march_pkg::*;
#(
  parameter int RW = 3,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          enable,
  input  walk_cfg_t     cfg,
  input  logic [RW-1:0] vrow,
  input  logic [CW-1:0] vcol,
  output logic [RW-1:0] row_q,
  output logic [CW-1:0] col_q,
  output logic          busy_q,
  output logic          done_q,
  output logic          row_phys_eff,
  output logic          col_phys_eff
);
  typedef struct packed {
    logic          last;
    logic [RW-1:0] r;
    logic [CW-1:0] c;
  } pos_t;

  function automatic pos_t adv(input pos_t p, input logic down, input logic [CW:0] stp,
                               input logic [RW-1:0] rlo, input logic [RW-1:0] rhi,
                               input logic [CW-1:0] clo, input logic [CW-1:0] chi);
    pos_t n;
    logic [CW:0] sum;
    n      = p;
    n.last = 1'b0;
    sum    = {1'b0, p.c} + stp;
    if (!down) begin
      if (sum <= {1'b0, chi}) n.c = sum[CW-1:0];
      else begin
        n.c    = clo;
        n.r    = p.r + 1'b1;
        n.last = (p.r == rhi);
      end
    end else begin
      if ({1'b0, p.c} >= ({1'b0, clo} + stp)) n.c = p.c - stp[CW-1:0];
      else begin
        n.c    = chi;
        n.r    = p.r - 1'b1;
        n.last = (p.r == rlo);
      end
    end
    return n;
  endfunction

  walk_cfg_t     cfg_q;
  logic [RW-1:0] rlo_q, rhi_q, vr_q;
  logic [CW-1:0] clo_q, chi_q, vc_q;
  logic [RW-1:0] s_rlo, s_rhi, row_d;
  logic [CW-1:0] s_clo, s_chi, col_d;
  logic [CW:0]   stp;
  logic          busy_d, done_d;
  pos_t          first, first_skip, cur, a1, a2;

  always_comb begin
    s_rlo = '0;
    s_rhi = '1;
    s_clo = '0;
    s_chi = '1;
    if (cfg.nbr) begin
      s_rlo = (vrow == '0) ? vrow : vrow - 1'b1;
      s_rhi = (vrow == '1) ? vrow : vrow + 1'b1;
      s_clo = (vcol == '0) ? vcol : vcol - 1'b1;
      s_chi = (vcol == '1) ? vcol : vcol + 1'b1;
    end
    first.last = 1'b0;
    first.r    = cfg.down ? s_rhi : s_rlo;
    first.c    = cfg.down ? s_chi : s_clo;
    first_skip = adv(first, cfg.down, (CW+1)'(1), s_rlo, s_rhi, s_clo, s_chi);

    stp        = (cfg_q.step2 && !cfg_q.nbr) ? (CW+1)'(2) : (CW+1)'(1);
    cur.last   = 1'b0;
    cur.r      = row_q;
    cur.c      = col_q;
    a1         = adv(cur, cfg_q.down, stp, rlo_q, rhi_q, clo_q, chi_q);
    a2         = adv(a1, cfg_q.down, stp, rlo_q, rhi_q, clo_q, chi_q);
  end

  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    busy_d = busy_q;
    done_d = done_q;
    if (start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      if (cfg.nbr && first.r == vrow && first.c == vcol) begin
        row_d  = first_skip.r;
        col_d  = first_skip.c;
        busy_d = !first_skip.last;
      end else begin
        row_d = first.r;
        col_d = first.c;
      end
    end else if (busy_q && enable) begin
      if (a1.last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else if (cfg_q.nbr && a1.r == vr_q && a1.c == vc_q) begin
        if (a2.last) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          row_d = a2.r;
          col_d = a2.c;
        end
      end else begin
        row_d = a1.r;
        col_d = a1.c;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rlo_q <= '0;
      rhi_q <= '0;
      clo_q <= '0;
      chi_q <= '0;
      vr_q  <= '0;
      vc_q  <= '0;
    end else if (start) begin
      cfg_q <= cfg;
      rlo_q <= s_rlo;
      rhi_q <= s_rhi;
      clo_q <= s_clo;
      chi_q <= s_chi;
      vr_q  <= vrow;
      vc_q  <= vcol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign row_phys_eff = cfg_q.row_phys | cfg_q.nbr;
  assign col_phys_eff = cfg_q.col_phys | cfg_q.nbr;

  // R8: the victim cell is never presented
  a_r8_victim_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cfg_q.nbr) |-> !(row_q == vr_q && col_q == vc_q));

  // R8: the position stays inside the latched window
  a_r8_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (row_q >= rlo_q && row_q <= rhi_q && col_q >= clo_q && col_q <= chi_q));

  // R7: the end of a walk always raises done
  a_r7_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(busy_q)) |-> done_q);

  // R7: start clears done and begins a walk
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && !done_q));
endmodule

// File: rtl/phys_march_agen.sv
module phys_march_agen
  import phys_march_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int ROW_ROT  = 1,
  parameter int ROW_MASK = 5,
  parameter int COL_ROT  = 2,
  parameter int COL_MASK = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         enable,
  input  logic                         dir_down,
  input  logic                         step_two,
  input  logic                         row_phys,
  input  logic                         col_phys,
  input  logic                         nbr_mode,
  input  logic [ROW_BITS-1:0]          victim_row,
  input  logic [COL_BITS-1:0]          victim_col,
  output logic [ROW_BITS+COL_BITS-1:0] addr_o,
  output logic [ROW_BITS-1:0]          phys_row_o,
  output logic [COL_BITS-1:0]          phys_col_o,
  output logic                         busy_o,
  output logic                         done_o
);
  logic [1:0]          rst_sync;
  logic                rst_s_n;
  walk_cfg_t           cfg;
  logic [ROW_BITS-1:0] wrow, lrow;
  logic [COL_BITS-1:0] wcol, lcol;
  logic                rphys_eff, cphys_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  always_comb begin
    cfg.down     = dir_down;
    cfg.step2    = step_two;
    cfg.row_phys = row_phys;
    cfg.col_phys = col_phys;
    cfg.nbr      = nbr_mode;
  end

  march_walk #(.RW(ROW_BITS), .CW(COL_BITS)) u_walk (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .start        (start),
    .enable       (enable),
    .cfg          (cfg),
    .vrow         (victim_row),
    .vcol         (victim_col),
    .row_q        (wrow),
    .col_q        (wcol),
    .busy_q       (busy_o),
    .done_q       (done_o),
    .row_phys_eff (rphys_eff),
    .col_phys_eff (cphys_eff)
  );

  fld_scramble #(.W(ROW_BITS), .ROT(ROW_ROT), .MASK(ROW_MASK)) u_row_map (
    .walk_val  (wrow),
    .phys_mode (rphys_eff),
    .phys_idx  (phys_row_o),
    .log_idx   (lrow)
  );

  fld_scramble #(.W(COL_BITS), .ROT(COL_ROT), .MASK(COL_MASK)) u_col_map (
    .walk_val  (wcol),
    .phys_mode (cphys_eff),
    .phys_idx  (phys_col_o),
    .log_idx   (lcol)
  );

  assign addr_o = {lrow, lcol};

  // R6: a paused walk keeps its address
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_o && !enable && !start) |=> $stable(addr_o));
endmodule

// File: tb/tb_phys_march_agen.sv
module tb_phys_march_agen;
  localparam int RB = 3, CB = 3, RROT = 1, RMASK = 5, CROT = 2, CMASK = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, enable = 0, dir_down = 0, step_two = 0;
  logic row_phys = 1, col_phys = 1, nbr_mode = 0;
  logic [RB-1:0] victim_row = '0;
  logic [CB-1:0] victim_col = '0;
  logic [RB+CB-1:0] addr_o;
  logic [RB-1:0] phys_row_o;
  logic [CB-1:0] phys_col_o;
  logic busy_o, done_o;

  int n_chk = 0, n_bad = 0;
  int exp_r[64], exp_c[64], exp_a[64];
  int n_exp;

  always #2 clk = ~clk;

  phys_march_agen #(.ROW_BITS(RB), .COL_BITS(CB), .ROW_ROT(RROT), .ROW_MASK(RMASK),
                    .COL_ROT(CROT), .COL_MASK(CMASK)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .dir_down(dir_down),
    .step_two(step_two), .row_phys(row_phys), .col_phys(col_phys), .nbr_mode(nbr_mode),
    .victim_row(victim_row), .victim_col(victim_col), .addr_o(addr_o),
    .phys_row_o(phys_row_o), .phys_col_o(phys_col_o), .busy_o(busy_o), .done_o(done_o));

  function automatic int rl3(input int x, input int k);
    return ((x << k) | (x >> (3 - k))) & 7;
  endfunction
  function automatic int rr3(input int x, input int k);
    return ((x >> k) | (x << (3 - k))) & 7;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic build(input bit dn, input bit s2, input bit rp, input bit cp, input bit nb,
                       input int vr, input int vc);
    int rlo, rhi, clo, chi, stp, pr, pc, lr, lc;
    n_exp = 0;
    stp = (s2 && !nb) ? 2 : 1;
    rlo = 0; rhi = 7; clo = 0; chi = 7;
    if (nb) begin
      rlo = (vr > 0) ? vr - 1 : 0; rhi = (vr < 7) ? vr + 1 : 7;
      clo = (vc > 0) ? vc - 1 : 0; chi = (vc < 7) ? vc + 1 : 7;
    end
    for (int i = 0; i <= rhi - rlo; i++) begin
      int wr;
      wr = dn ? rhi - i : rlo + i;
      for (int j = 0; j <= chi - clo; j += stp) begin
        int wc;
        wc = dn ? chi - j : clo + j;
        if (nb && wr == vr && wc == vc) continue;
        if (rp || nb) begin pr = wr; lr = rl3(wr, RROT) ^ RMASK; end
        else begin lr = wr; pr = rr3(wr ^ RMASK, RROT); end
        if (cp || nb) begin pc = wc; lc = rl3(wc, CROT) ^ CMASK; end
        else begin lc = wc; pc = rr3(wc ^ CMASK, CROT); end
        exp_r[n_exp] = pr; exp_c[n_exp] = pc; exp_a[n_exp] = lr * 8 + lc;
        n_exp++;
      end
    end
  endtask

  task automatic run_walk(input string req, input bit dn, input bit s2, input bit rp,
                          input bit cp, input bit nb, input int vr, input int vc,
                          input int hold_at);
    build(dn, s2, rp, cp, nb, vr, vc);
    @(negedge clk);
    dir_down = dn; step_two = s2; row_phys = rp; col_phys = cp; nbr_mode = nb;
    victim_row = vr[RB-1:0]; victim_col = vc[CB-1:0];
    start = 1; enable = 1;
    @(negedge clk);
    start = 0;
    chk({req, " R7 done cleared by start"}, done_o, 0);
    for (int k = 0; k < n_exp; k++) begin
      if (k > 0) @(negedge clk);
      chk({req, " busy"}, busy_o, 1);
      chk({req, " addr"}, addr_o, exp_a[k]);
      chk({req, " prow"}, phys_row_o, exp_r[k]);
      chk({req, " pcol"}, phys_col_o, exp_c[k]);
      if (k == hold_at) begin
        enable = 0;
        for (int h = 0; h < 4; h++) begin
          @(negedge clk);
          chk("R6 hold addr", addr_o, exp_a[k]);
          chk("R6 hold prow", phys_row_o, exp_r[k]);
        end
        enable = 1;
      end
    end
    @(negedge clk);
    chk({req, " R7 done after last"}, done_o, 1);
    chk({req, " R7 busy after last"}, busy_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy at reset", busy_o, 0);
    chk("R1 done at reset", done_o, 0);
  endtask

  task automatic t_done_holds;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 done persists", done_o, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    run_walk("R2 R4 phys up", 0, 0, 1, 1, 0, 0, 0, -1);
    t_done_holds();
    run_walk("R4 phys down", 1, 0, 1, 1, 0, 0, 0, -1);
    run_walk("R3 logical both", 0, 0, 0, 0, 0, 0, 0, -1);
    run_walk("R3 mixed rphys clog", 0, 0, 1, 0, 0, 0, 0, -1);
    run_walk("R3 mixed rlog cphys down", 1, 0, 0, 1, 0, 0, 0, -1);
    run_walk("R5 step2 up", 0, 1, 1, 1, 0, 0, 0, -1);
    run_walk("R5 step2 down", 1, 1, 1, 1, 0, 0, 0, -1);
    run_walk("R6 pause", 0, 0, 1, 1, 0, 0, 0, 2);
    run_walk("R8 nbr corner up", 0, 1, 0, 0, 1, 0, 0, -1);
    run_walk("R8 nbr interior down", 1, 0, 1, 1, 1, 4, 3, -1);
    run_walk("R8 nbr edge up", 0, 0, 1, 1, 1, 7, 3, -1);
    run_walk("R8 nbr far corner down", 1, 0, 1, 1, 1, 7, 7, 1);
    chk("R8 nbr corner count", n_exp, 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule